// File: doc/BRIEF.md
# Card Clock Generator with Phase Strobes

This block produces the clock for a memory-card bus. It picks one of two reference ticks: a slow crystal-class tick or a fast PLL-class tick. It divides that tick by an integer ratio and drives the result as a square card clock. Alongside the clock it raises three single-cycle strobes for the core, transmit and receive sampling points. Each strobe can sit at a quarter-period step within the card clock period. Both references are modelled as clock enables in the system clock domain, so the whole block runs on one clock.

A host controller drives one configuration word. That word carries the divide ratio, the source choice, the three phase codes, a stop bit and an always-on bit. The divide, source and phase fields are copied into an internal settings register only while the stop bit is set and the clock has come to rest. This keeps a running clock free of glitches.

The clock can run in two ways. In always-on mode it runs whenever it is not stopped. In automatic mode it runs only while the controller reports busy. Starts and stops happen only at the end of a low phase, so no shortened pulse ever reaches the card. A status output shows whether the clock is running.

Top module: `cardclk_gen`

## Requirements
- R1: Source field, word bits 7:6: code 0 takes ticks from `xtal_en_i`, code 1 takes them from `pll_en_i`. Codes 2 and 3 select no reference, so the clock stays low and `clk_running_o` stays 0.
- R2: Divide field, word bits 5:0, holds a ratio N counted from one, up to 63. One card clock period lasts N reference ticks. The high part lasts floor(N/2) ticks and the low part lasts the rest, so an odd N gives a high part one tick shorter than the low part. A ratio of 1 runs as ratio 2.
- R3: A divide field of 0 keeps the card clock off and `clk_running_o` at 0.
- R4: The phase fields are core at bits 9:8, transmit at bits 11:10 and receive at bits 13:12. Code p means p quarter periods (0, 90, 180 or 270 degrees). Each strobe is one system cycle high once per period, floor(p*N/4) ticks after the rising edge; phase 0 coincides with the rise.
- R5: While stop (bit 14) is 1, the clock is held low. A stop raised mid-period lets the current high and low parts finish at full length before the clock rests.
- R6: The divide, source and phase fields take effect only if they are written while stop is 1 and the clock is at rest. Changes made at any other time have no effect on the output.
- R7: With bit 15 at 0 (automatic mode), the clock runs only while `busy_i` is 1, and a drop of busy lets the current period finish. With bit 15 at 1, it runs regardless of busy.
- R8: After reset the settings are: crystal source, ratio 63, core phase code 2 (180 degrees), transmit and receive phase code 0. All outputs are low during reset.
- R9: `clk_running_o` is 1 exactly while the divider is producing periods; the card clock is never high while it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xtal_en_i | input | 1 | Crystal-class reference tick |
| pll_en_i | input | 1 | PLL-class reference tick |
| cfg_i | input | 16 | Configuration word: ratio, source, phases, stop, always-on |
| busy_i | input | 1 | Controller busy, used in automatic mode |
| card_clk_o | output | 1 | Divided card clock |
| core_stb_o | output | 1 | Core sampling strobe |
| tx_stb_o | output | 1 | Transmit sampling strobe |
| rx_stb_o | output | 1 | Receive sampling strobe |
| clk_running_o | output | 1 | Card clock is running |

## Verification
The bench builds the block with its default parameters: a 6-bit divide field, 2-bit phase codes and a 16-bit word. With a 6-bit field the slowest reset rate (ratio 63 on the crystal tick) and the largest ratio on the fast tick fit in a short run. The fast tick is held high every cycle, so a period measured in system cycles equals N. The crystal tick fires every third cycle, so the two sources give periods in a 3:1 ratio. Odd, even, clamped and maximum ratios are each measured against hand-computed high, low and strobe offsets.

// File: rtl/cardclk_pkg.sv
`timescale 1ns/1ps
package cardclk_pkg;
    localparam int DIV_W  = 6;
    localparam int PH_W   = 2;
    localparam int SRC_W  = 2;
    localparam int NUM_PH = 3;

    typedef enum logic [SRC_W-1:0] {
        SRC_XTAL = 2'd0,
        SRC_PLL  = 2'd1,
        SRC_OFF2 = 2'd2,
        SRC_OFF3 = 2'd3
    } clk_src_e;

    typedef struct packed {
        logic [PH_W-1:0]  rx_ph;
        logic [PH_W-1:0]  tx_ph;
        logic [PH_W-1:0]  core_ph;
        clk_src_e         src;
        logic [DIV_W-1:0] div;
    } clk_set_t;

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             clk;
        logic             run;
    } div_state_t;
endpackage

// File: rtl/cardclk_shadow.sv
`timescale 1ns/1ps
module cardclk_shadow
    import cardclk_pkg::*;
#(
    parameter int CFG_W    = 16,
    parameter int STOP_POS = 14,
    parameter int AON_POS  = 15,
    parameter int RST_DIV  = 63,
    parameter int RST_CORE = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CFG_W-1:0] cfg_i,
    input  logic             running_i,
    output clk_set_t         set_o,
    output logic             stop_o,
    output logic             aon_o
);
    localparam int SRC_LSB  = DIV_W;
    localparam int CORE_LSB = SRC_LSB + SRC_W;
    localparam int TX_LSB   = CORE_LSB + PH_W;
    localparam int RX_LSB   = TX_LSB + PH_W;
    localparam clk_set_t RST_SET = '{
        rx_ph:   '0,
        tx_ph:   '0,
        core_ph: PH_W'(RST_CORE),
        src:     SRC_XTAL,
        div:     DIV_W'(RST_DIV)
    };

    clk_set_t set_d, set_q, decoded;
    logic     load;

    always_comb begin
        decoded.div     = cfg_i[SRC_LSB-1:0];
        decoded.src     = clk_src_e'(cfg_i[SRC_LSB +: SRC_W]);
        decoded.core_ph = cfg_i[CORE_LSB +: PH_W];
        decoded.tx_ph   = cfg_i[TX_LSB +: PH_W];
        decoded.rx_ph   = cfg_i[RX_LSB +: PH_W];
        // settings follow the word only while stopped and at rest
        load  = cfg_i[STOP_POS] && !running_i;
        set_d = load ? decoded : set_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) set_q <= RST_SET;
        else        set_q <= set_d;
    end

    assign set_o  = set_q;
    assign stop_o = cfg_i[STOP_POS];
    assign aon_o  = cfg_i[AON_POS];

    p_hold_cfg_r6: assert property (@(posedge clk) disable iff (!rst_n)
        running_i |=> $stable(set_q));
endmodule

// File: rtl/cardclk_div.sv
`timescale 1ns/1ps
module cardclk_div
    import cardclk_pkg::*;
#(
    parameter int CNT_W = DIV_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  clk_src_e         src_i,
    input  logic [CNT_W-1:0] div_i,
    input  logic             xtal_en_i,
    input  logic             pll_en_i,
    input  logic             stop_i,
    input  logic             aon_i,
    input  logic             busy_i,
    output logic             clk_o,
    output logic             running_o,
    output logic             adv_o,
    output logic [CNT_W-1:0] cnt_nx_o,
    output logic [CNT_W-1:0] n_eff_o
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
    localparam logic [CNT_W-1:0] TWO = CNT_W'(2);

    div_state_t       st_d, st_q;
    logic             tick, last, run_req, adv;
    logic [CNT_W-1:0] n_eff, hi_len;

    always_comb begin
        case (src_i)
            SRC_XTAL: tick = xtal_en_i;
            SRC_PLL:  tick = pll_en_i;
            default:  tick = 1'b0;
        endcase
        n_eff   = (div_i == ONE) ? TWO : div_i;
        hi_len  = n_eff >> 1;
        last    = (st_q.cnt == n_eff - ONE);
        run_req = !stop_i && (aon_i || busy_i) && (div_i != '0);
        st_d    = st_q;
        adv     = 1'b0;
        if (tick) begin
            if (st_q.run) begin
                if (last) begin
                    // end of low part: the only point to start or stop
                    st_d.cnt = '0;
                    if (run_req) begin
                        st_d.clk = 1'b1;
                        adv      = 1'b1;
                    end else begin
                        st_d.clk = 1'b0;
                        st_d.run = 1'b0;
                    end
                end else begin
                    st_d.cnt = st_q.cnt + ONE;
                    st_d.clk = (st_d.cnt < hi_len);
                    adv      = 1'b1;
                end
            end else if (run_req) begin
                st_d.run = 1'b1;
                st_d.cnt = '0;
                st_d.clk = 1'b1;
                adv      = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign clk_o     = st_q.clk;
    assign running_o = st_q.run;
    assign adv_o     = adv;
    assign cnt_nx_o  = st_d.cnt;
    assign n_eff_o   = n_eff;

    p_clk_needs_run_r9: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.clk |-> st_q.run);
    p_zero_div_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (div_i == '0) |-> !st_q.run);
    p_stop_rest_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_i && !st_q.run) |=> !st_q.run);
    p_no_source_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (src_i[1] && !st_q.run) |=> !st_q.run);
    p_cnt_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.run |-> (st_q.cnt < n_eff));
endmodule

// File: rtl/cardclk_phase.sv
`timescale 1ns/1ps
module cardclk_phase
    import cardclk_pkg::*;
#(
    parameter int CNT_W  = DIV_W,
    parameter int CODE_W = PH_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv_i,
    input  logic              run_i,
    input  logic [CNT_W-1:0]  cnt_nx_i,
    input  logic [CNT_W-1:0]  n_eff_i,
    input  logic [CODE_W-1:0] code_i,
    output logic              stb_o
);
    localparam int QW    = CNT_W + CODE_W + 1;
    localparam int STEPS = 2 ** CODE_W;

    logic [QW-1:0] prod, base;
    logic          hit;
    logic          stb_d, stb_q;

    always_comb begin
        // offset = floor(code * N / STEPS); hit when cnt equals it
        prod  = QW'(code_i) * QW'(n_eff_i);
        base  = {1'b0, cnt_nx_i, {CODE_W{1'b0}}};
        hit   = (base <= prod) && (prod < base + QW'(STEPS));
        stb_d = adv_i && hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stb_q <= 1'b0;
        else        stb_q <= stb_d;
    end

    assign stb_o = stb_q;

    p_strobe_in_run_r4: assert property (@(posedge clk) disable iff (!rst_n)
        stb_q |-> run_i);
    p_strobe_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        stb_q |=> !stb_q);
endmodule

// File: rtl/cardclk_gen.sv
`timescale 1ns/1ps
module cardclk_gen
    import cardclk_pkg::*;
#(
    parameter int CFG_W    = 16,
    parameter int STOP_POS = 14,
    parameter int AON_POS  = 15,
    parameter int RST_DIV  = 63,
    parameter int RST_CORE = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             xtal_en_i,
    input  logic             pll_en_i,
    input  logic [CFG_W-1:0] cfg_i,
    input  logic             busy_i,
    output logic             card_clk_o,
    output logic             core_stb_o,
    output logic             tx_stb_o,
    output logic             rx_stb_o,
    output logic             clk_running_o
);
    clk_set_t          set;
    logic              stop, aon, running, adv;
    logic [DIV_W-1:0]  cnt_nx, n_eff;
    logic [PH_W-1:0]   ph_code [NUM_PH];
    logic [NUM_PH-1:0] stb_vec;

    cardclk_shadow #(
        .CFG_W(CFG_W), .STOP_POS(STOP_POS), .AON_POS(AON_POS),
        .RST_DIV(RST_DIV), .RST_CORE(RST_CORE)
    ) u_shadow (
        .clk(clk), .rst_n(rst_n), .cfg_i(cfg_i), .running_i(running),
        .set_o(set), .stop_o(stop), .aon_o(aon)
    );

    cardclk_div #(.CNT_W(DIV_W)) u_div (
        .clk(clk), .rst_n(rst_n), .src_i(set.src), .div_i(set.div),
        .xtal_en_i(xtal_en_i), .pll_en_i(pll_en_i),
        .stop_i(stop), .aon_i(aon), .busy_i(busy_i),
        .clk_o(card_clk_o), .running_o(running), .adv_o(adv),
        .cnt_nx_o(cnt_nx), .n_eff_o(n_eff)
    );

    assign ph_code[0] = set.core_ph;
    assign ph_code[1] = set.tx_ph;
    assign ph_code[2] = set.rx_ph;

    for (genvar g = 0; g < NUM_PH; g++) begin : g_phase
        cardclk_phase #(.CNT_W(DIV_W), .CODE_W(PH_W)) u_ph (
            .clk(clk), .rst_n(rst_n), .adv_i(adv), .run_i(running),
            .cnt_nx_i(cnt_nx), .n_eff_i(n_eff), .code_i(ph_code[g]),
            .stb_o(stb_vec[g])
        );
    end

    assign core_stb_o    = stb_vec[0];
    assign tx_stb_o      = stb_vec[1];
    assign rx_stb_o      = stb_vec[2];
    assign clk_running_o = running;
endmodule

// File: tb/cardclk_gen_tb_top.sv
`timescale 1ns/1ps
module cardclk_gen_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        xtal_en;
    logic        pll_en;
    logic [15:0] cfg;
    logic        busy;
    logic        card_clk, core_stb, tx_stb, rx_stb, running;
    int          checks = 0;
    int          errors = 0;

    always #4 clk = ~clk;
    assign pll_en = 1'b1;

    cardclk_gen dut_i (
        .clk(clk), .rst_n(rst_n), .xtal_en_i(xtal_en), .pll_en_i(pll_en),
        .cfg_i(cfg), .busy_i(busy), .card_clk_o(card_clk),
        .core_stb_o(core_stb), .tx_stb_o(tx_stb), .rx_stb_o(rx_stb),
        .clk_running_o(running)
    );

    // crystal tick: one cycle in three
    initial begin
        int xc = 0;
        xtal_en = 1'b0;
        forever begin
            @(negedge clk);
            xc = (xc == 2) ? 0 : xc + 1;
            xtal_en = (xc == 0);
        end
    end

    // fields: src, div, core, tx, rx, hi, lo, core_off, tx_off, rx_off (cycles)
    localparam logic [53:0] VECS [8] = '{
        {2'd1, 6'd4,  2'd0, 2'd1, 2'd2, 8'd2,  8'd2,  8'd0,  8'd1,  8'd2},
        {2'd1, 6'd5,  2'd1, 2'd2, 2'd3, 8'd2,  8'd3,  8'd1,  8'd2,  8'd3},
        {2'd1, 6'd7,  2'd3, 2'd0, 2'd1, 8'd3,  8'd4,  8'd5,  8'd0,  8'd1},
        {2'd1, 6'd1,  2'd2, 2'd1, 2'd3, 8'd1,  8'd1,  8'd1,  8'd0,  8'd1},
        {2'd1, 6'd63, 2'd2, 2'd3, 2'd0, 8'd31, 8'd32, 8'd31, 8'd47, 8'd0},
        {2'd1, 6'd2,  2'd1, 2'd2, 2'd3, 8'd1,  8'd1,  8'd0,  8'd1,  8'd1},
        {2'd0, 6'd6,  2'd1, 2'd2, 2'd3, 8'd9,  8'd9,  8'd3,  8'd9,  8'd12},
        {2'd1, 6'd3,  2'd0, 2'd1, 2'd2, 8'd1,  8'd2,  8'd0,  8'd0,  8'd1}
    };

    function automatic logic [15:0] mk(input bit aon, input bit stp, input int src,
                                       input int div, input int c, input int t, input int r);
        return {aon, stp, 2'(r), 2'(t), 2'(c), 2'(src), 6'(div)};
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_rise();
        int g = 0;
        while (card_clk !== 1'b0 && g < 2000) begin @(negedge clk); g++; end
        while (card_clk !== 1'b1 && g < 4000) begin @(negedge clk); g++; end
    endtask

    task automatic measure(output int hi, output int lo, output int oc,
                           output int ot, output int orr);
        bit in_low = 1'b0;
        hi = 0; lo = 0; oc = -1; ot = -1; orr = -1;
        wait_rise();
        for (int t = 0; t < 1000; t++) begin
            if (in_low && card_clk) break;
            if (core_stb && oc < 0) oc = t;
            if (tx_stb && ot < 0) ot = t;
            if (rx_stb && orr < 0) orr = t;
            if (!in_low && card_clk) hi++;
            else begin in_low = 1'b1; lo++; end
            @(negedge clk);
        end
    endtask

    task automatic count_high(input int n, output int highs);
        highs = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (card_clk) highs++;
        end
    endtask

    task automatic high_run(output int n);
        n = 0;
        while (card_clk && n < 1000) begin n++; @(negedge clk); end
    endtask

    task automatic apply(input int src, input int div, input int c, input int t, input int r);
        int g = 0;
        cfg = mk(1'b1, 1'b1, src, div, c, t, r);
        while (running && g < 2000) begin @(negedge clk); g++; end
        repeat (2) @(negedge clk);
        cfg = mk(1'b1, 1'b0, src, div, c, t, r);
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog actual hung expected done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int hi, lo, oc, ot, orr, n;
        rst_n = 1'b0; busy = 1'b0;
        cfg = mk(1'b1, 1'b0, 1, 5, 0, 1, 1);
        repeat (5) @(negedge clk);
        chk("R8 clk in reset", int'(card_clk), 0);
        chk("R8 running in reset", int'(running), 0);
        chk("R8 strobes in reset", int'({core_stb, tx_stb, rx_stb}), 0);
        rst_n = 1'b1;
        // reset settings: crystal, ratio 63, core 180, tx/rx 0; word fields not loaded (R6)
        measure(hi, lo, oc, ot, orr);
        chk("R8 high", hi, 93);
        chk("R8 low", lo, 96);
        chk("R8 core offset", oc, 93);
        chk("R8 tx offset", ot, 0);
        chk("R8 rx offset", orr, 0);

        for (int i = 0; i < 8; i++) begin
            logic [53:0] v = VECS[i];
            apply(int'(v[53:52]), int'(v[51:46]), int'(v[45:44]), int'(v[43:42]), int'(v[41:40]));
            measure(hi, lo, oc, ot, orr);
            chk(v[53:52] == 2'd0 ? "R1 crystal high" : "R2 high", hi, int'(v[39:32]));
            chk("R2 low", lo, int'(v[31:24]));
            chk("R4 core offset", oc, int'(v[23:16]));
            chk("R4 tx offset", ot, int'(v[15:8]));
            chk("R4 rx offset", orr, int'(v[7:0]));
            chk("R9 running", int'(running), 1);
        end

        // R6: word changes without stop have no effect
        apply(1, 4, 0, 1, 2);
        cfg = mk(1'b1, 1'b0, 1, 9, 3, 3, 3);
        measure(hi, lo, oc, ot, orr);
        chk("R6 high kept", hi, 2);
        chk("R6 low kept", lo, 2);
        chk("R6 core kept", oc, 0);
        chk("R6 tx kept", ot, 1);
        chk("R6 rx kept", orr, 2);

        // R5: stop mid-period completes the high part, then rests
        apply(1, 8, 0, 0, 0);
        wait_rise();
        cfg = mk(1'b1, 1'b1, 1, 8, 0, 0, 0);
        high_run(n);
        chk("R5 no runt high", n, 4);
        count_high(40, n);
        chk("R5 held low", n, 0);
        chk("R9 idle after stop", int'(running), 0);
        busy = 1'b1;
        count_high(100, n);
        chk("R5 stop beats busy", n, 0);

        // R7: automatic mode
        busy = 1'b0;
        cfg = mk(1'b0, 1'b0, 1, 8, 0, 0, 0);
        count_high(100, n);
        chk("R7 idle without busy", n, 0);
        chk("R7 running without busy", int'(running), 0);
        busy = 1'b1;
        measure(hi, lo, oc, ot, orr);
        chk("R7 busy high", hi, 4);
        chk("R7 busy low", lo, 4);
        wait_rise();
        busy = 1'b0;
        high_run(n);
        chk("R7 busy drop no runt", n, 4);
        count_high(40, n);
        chk("R7 rest after busy", n, 0);
        chk("R7 running after busy", int'(running), 0);
        busy = 1'b1;

        // R3: ratio 0 gates off
        apply(1, 0, 0, 0, 0);
        count_high(200, n);
        chk("R3 zero ratio high", n, 0);
        chk("R3 zero ratio running", int'(running), 0);

        // R1: codes 2 and 3 select nothing
        apply(2, 4, 0, 0, 0);
        count_high(200, n);
        chk("R1 code2 high", n, 0);
        chk("R1 code2 running", int'(running), 0);
        apply(3, 4, 0, 0, 0);
        count_high(200, n);
        chk("R1 code3 high", n, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule